// File: doc/BRIEF.md
# Serial Flash Command Sequencer

This block sits between a request source and a byte-exchange SPI master. It turns one request into the chip-select frames that a serial NOR or page-based flash expects. A request is a read, a sector erase or a program, together with a 24-bit address, a byte count and a vendor class. For writes on standard parts the block first sends a write-enable frame and polls the latch. It then sends the command frame. Program data is drawn from an input stream in bursts of bounded length. After each erase or program burst the block polls the status register until the part reports ready, or until a cycle-count timeout runs out.

The byte exchange works as follows. `xferStart` pulses for one cycle with `xferTx` valid. The master later pulses `xferDone` with the received byte on `xferRx`. `csActive` frames each transaction. Read data appears on `rdData` with a one-cycle `rdValid` strobe. Completion is a single-cycle `done`, qualified by `error` and `timeout`.

The vendor class is a 2-bit code, normally taken from an identification probe made elsewhere:
- `00` is a standard part with erase 0xD8.
- `01` is a standard part with erase 0x20.
- `1x` is the alternate class.

Top module: `flash_cmd_seq`

## Requirements
- R1: A read (reqOp=00) opens one frame. It sends 0x0B, then the address high, middle and low bytes, then one 0x00 dummy byte. With FAST_READ=0 it sends 0x03 and no dummy byte.
- R2: A read then exchanges reqCount bytes of 0x00 and presents each received byte, in order, on rdData with one rdValid pulse per byte. The frame then closes and done pulses.
- R3: For classes 00 and 01, program (reqOp=10) uses 0x02 and the status read uses 0x05. Erase (reqOp=01) uses 0xD8 for class 00 and 0x20 for class 01. Each command opcode is followed by the three address bytes, high byte first.
- R4: For classes 10 and 11, program uses 0x82, erase uses 0x81 and the status read uses 0xD7. No write-enable frame is sent.
- R5: On classes 00 and 01, each erase and each program burst is preceded by a frame holding only 0x06. Status frames follow until bit 1 of the status is set, and only then is the command frame sent.
- R6: Each status read is its own frame: the status opcode, then a 0x00 dummy byte whose response is the status value. Ready means bit 0 clear on classes 00 and 01, with bit 7 ignored. Ready means bit 7 set on the alternate class, with bit 0 ignored.
- R7: A program burst carries at most PROG_LEN data bytes, taken from wrData with one wrTake pulse per byte. Longer requests repeat the whole sequence, with the address advanced by the bytes already sent, until reqCount bytes are written.
- R8: If a status poll phase lasts TIMEOUT_CYC cycles without success, the block ends with done, error and timeout all high and chip select released. The next request then runs normally.
- R9: xferStart is only raised while csActive is high. csActive is low for at least one cycle between frames.
- R10: After reset, done, csActive and xferStart are low. done is a one-cycle pulse. Reserved reqOp=11 completes with done and error and no frame.
- R11: A program with reqCount=0 completes without error and sends no frame. A read with reqCount=0 sends only its header frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request strobe, taken when idle |
| reqOp | input | 2 | 00 read, 01 erase, 10 program, 11 reserved |
| reqClass | input | 2 | Vendor class code |
| reqAddr | input | 24 | Start byte address |
| reqCount | input | CNT_W | Byte count for read or program |
| wrData | input | 8 | Program data stream head |
| wrTake | output | 1 | Current wrData byte consumed |
| rdData | output | 8 | Read data byte |
| rdValid | output | 1 | rdData valid strobe |
| csActive | output | 1 | Flash chip select active |
| xferStart | output | 1 | Start one byte exchange |
| xferTx | output | 8 | Byte to transmit |
| xferDone | input | 1 | Byte exchange complete |
| xferRx | input | 8 | Byte received |
| done | output | 1 | Request finished |
| error | output | 1 | Request failed (with done) |
| timeout | output | 1 | Failure was a poll timeout (with done) |

## Verification
The bench models a flash that keeps a write-enable latch and holds a busy count that the caller chooses. While busy, the standard status carries bit 7 set and the alternate status carries bit 0 set. A sequencer that tests the wrong bit polarity therefore stops polling too early or polls forever, and the byte stream comparison exposes it. A program longer than the burst limit checks that the address advances and that the write-enable step repeats per burst. A wrong burst cap or a missing address update would show up as wrong frame bytes. A stuck-busy part checks the timeout exit, and the read that follows checks that the block recovers. Zero counts and the reserved operation check the cases where the block must send nothing at all, or only a header.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_ERASE = 2'b01,
    OP_PROG  = 2'b10,
    OP_RSVD  = 2'b11
  } op_e;

  // control-to-datapath strobes
  typedef struct packed {
    logic load;       // capture request fields
    logic burstLoad;  // arm next program burst
    logic capBurst;   // limit burst to PROG_LEN
    logic dataStep;   // one data byte exchanged
    logic rdCapture;  // register a read byte
    logic pollClr;    // restart poll timer
    logic pollRun;    // poll timer advances
  } strobe_t;

  function automatic logic [7:0] opStatus(input logic [1:0] cls);
    return cls[1] ? 8'hD7 : 8'h05;
  endfunction

  function automatic logic [7:0] opErase(input logic [1:0] cls);
    return cls[1] ? 8'h81 : (cls[0] ? 8'h20 : 8'hD8);
  endfunction

  function automatic logic [7:0] opProg(input logic [1:0] cls);
    return cls[1] ? 8'h82 : 8'h02;
  endfunction

endpackage

// File: rtl/fcs_dp.sv
module fcs_dp
  import fcs_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int PROG_LEN    = 256,
  parameter int TIMEOUT_CYC = 1000
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          st,
  input  logic [23:0]      reqAddr,
  input  logic [CNT_W-1:0] reqCount,
  input  logic [7:0]       xferRx,
  output logic [23:0]      addr,
  output logic             burstLast,
  output logic             burstZero,
  output logic             remainZero,
  output logic             tmoHit,
  output logic [7:0]       rdData,
  output logic             rdValid
);

  localparam int TMR_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [TMR_W-1:0] TMR_LIM = TMR_W'(TIMEOUT_CYC);
  localparam logic [CNT_W-1:0] BURST_MAX = CNT_W'(PROG_LEN);

  logic [CNT_W-1:0] remain;
  logic [CNT_W-1:0] burst;
  logic [TMR_W-1:0] tmr;

  function automatic logic [CNT_W-1:0] capTo(input logic [CNT_W-1:0] n, input logic cap);
    return (cap && n > BURST_MAX) ? BURST_MAX : n;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addr   <= '0;
      remain <= '0;
      burst  <= '0;
    end else if (st.load) begin
      addr   <= reqAddr;
      remain <= reqCount;
      burst  <= capTo(reqCount, st.capBurst);
    end else if (st.burstLoad) begin
      burst  <= capTo(remain, st.capBurst);
    end else if (st.dataStep) begin
      addr   <= addr + 24'd1;
      remain <= remain - 1'b1;
      burst  <= burst - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                             tmr <= '0;
    else if (st.pollClr)                   tmr <= '0;
    else if (st.pollRun && tmr < TMR_LIM)  tmr <= tmr + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= st.rdCapture;
      if (st.rdCapture) rdData <= xferRx;
    end
  end

  assign burstLast  = (burst == CNT_W'(1));
  assign burstZero  = (burst == '0);
  assign remainZero = (remain == '0);
  assign tmoHit     = (tmr >= TMR_LIM);

  p_tmr_sat_r8: assert property (@(posedge clk) disable iff (!rstN) tmr <= TMR_LIM)
    else $error("poll timer ran past its limit");

  p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rstN)
    st.dataStep |-> (remain != '0 && burst != '0))
    else $error("data step with nothing left");

endmodule

// File: rtl/fcs_ctrl.sv
module fcs_ctrl
  import fcs_pkg::*;
#(
  parameter bit FAST_READ = 1'b1,
  parameter int CNT_W     = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [1:0]       reqOp,
  input  logic [1:0]       reqClass,
  input  logic [CNT_W-1:0] reqCount,
  input  logic [23:0]      addr,
  input  logic             burstLast,
  input  logic             burstZero,
  input  logic             remainZero,
  input  logic             tmoHit,
  input  logic             xferDone,
  input  logic [2:0]       statKey,   // {status[7], status[1], status[0]}
  input  logic [7:0]       wrData,
  output strobe_t          st,
  output logic             xferStart,
  output logic [7:0]       xferTx,
  output logic             wrTake,
  output logic             csActive,
  output logic             done,
  output logic             error,
  output logic             timeout
);

  typedef enum logic [3:0] {
    S_IDLE, S_WREN, S_GAP, S_STOP, S_SDUM, S_CMD,
    S_A2, S_A1, S_A0, S_DUMMY, S_DATA, S_FIN
  } state_e;

  state_e state, stateN, gapNext, gapNextN;
  op_e    opReg, opRegN;
  logic [1:0] clsReg, clsRegN;
  logic pending, pollRdy, pollRdyN, inPoll, inPollN;
  logic errFlag, errFlagN, tmoFlag, tmoFlagN;
  logic isByte, byteDone, statOk;

  always_comb begin
    isByte = state inside {S_WREN, S_STOP, S_SDUM, S_CMD, S_A2, S_A1, S_A0, S_DUMMY, S_DATA};
    xferStart = isByte && !pending;
    byteDone  = pending && xferDone;
    csActive  = !(state inside {S_IDLE, S_GAP, S_FIN});
    wrTake    = xferStart && state == S_DATA && opReg == OP_PROG;
    unique case (state)
      S_WREN:  xferTx = 8'h06;
      S_STOP:  xferTx = opStatus(clsReg);
      S_CMD:   xferTx = (opReg == OP_READ)  ? (FAST_READ ? 8'h0B : 8'h03) :
                        (opReg == OP_ERASE) ? opErase(clsReg) : opProg(clsReg);
      S_A2:    xferTx = addr[23:16];
      S_A1:    xferTx = addr[15:8];
      S_A0:    xferTx = addr[7:0];
      S_DATA:  xferTx = (opReg == OP_PROG) ? wrData : 8'h00;
      default: xferTx = 8'h00;
    endcase
    // write-enable latch on bit 1; ready polarity per class
    statOk = !pollRdy ? statKey[1] : (clsReg[1] ? statKey[2] : !statKey[0]);
  end

  always_comb begin
    stateN   = state;
    gapNextN = gapNext;
    opRegN   = opReg;
    clsRegN  = clsReg;
    pollRdyN = pollRdy;
    inPollN  = inPoll;
    errFlagN = errFlag;
    tmoFlagN = tmoFlag;
    st           = '0;
    st.capBurst  = (state == S_IDLE) ? (reqOp == OP_PROG) : (opReg == OP_PROG);
    st.pollRun   = inPoll;
    st.dataStep  = byteDone && state == S_DATA;
    st.rdCapture = byteDone && state == S_DATA && opReg == OP_READ;
    unique case (state)
      S_IDLE: if (reqValid) begin
        opRegN = op_e'(reqOp);
        clsRegN = reqClass;
        errFlagN = 1'b0;
        tmoFlagN = 1'b0;
        if (op_e'(reqOp) == OP_RSVD) begin
          errFlagN = 1'b1;
          stateN = S_FIN;
        end else if (op_e'(reqOp) == OP_PROG && reqCount == '0) begin
          stateN = S_FIN;
        end else begin
          st.load = 1'b1;
          stateN = (op_e'(reqOp) != OP_READ && !reqClass[1]) ? S_WREN : S_CMD;
        end
      end
      S_WREN: if (byteDone) begin
        stateN = S_GAP; gapNextN = S_STOP;
        pollRdyN = 1'b0; inPollN = 1'b1; st.pollClr = 1'b1;
      end
      S_GAP: begin
        if (inPoll && tmoHit) begin
          errFlagN = 1'b1; tmoFlagN = 1'b1; inPollN = 1'b0;
          stateN = S_FIN;
        end else begin
          stateN = gapNext;
        end
      end
      S_STOP: if (byteDone) stateN = S_SDUM;
      S_SDUM: if (byteDone) begin
        stateN = S_GAP;
        if (!statOk) begin
          gapNextN = S_STOP;
        end else begin
          inPollN = 1'b0;
          if (!pollRdy) begin
            gapNextN = S_CMD;
          end else if (opReg == OP_PROG && !remainZero) begin
            st.burstLoad = 1'b1;
            gapNextN = clsReg[1] ? S_CMD : S_WREN;
          end else begin
            stateN = S_FIN;
          end
        end
      end
      S_CMD: if (byteDone) stateN = S_A2;
      S_A2:  if (byteDone) stateN = S_A1;
      S_A1:  if (byteDone) stateN = S_A0;
      S_A0: if (byteDone) begin
        unique case (opReg)
          OP_READ:  stateN = FAST_READ ? S_DUMMY : (burstZero ? S_FIN : S_DATA);
          OP_ERASE: begin
            stateN = S_GAP; gapNextN = S_STOP;
            pollRdyN = 1'b1; inPollN = 1'b1; st.pollClr = 1'b1;
          end
          default:  stateN = S_DATA;
        endcase
      end
      S_DUMMY: if (byteDone) stateN = burstZero ? S_FIN : S_DATA;
      S_DATA: if (byteDone && burstLast) begin
        if (opReg == OP_READ) begin
          stateN = S_FIN;
        end else begin
          stateN = S_GAP; gapNextN = S_STOP;
          pollRdyN = 1'b1; inPollN = 1'b1; st.pollClr = 1'b1;
        end
      end
      S_FIN: stateN = S_IDLE;
      default: stateN = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      gapNext <= S_IDLE;
      opReg   <= OP_READ;
      clsReg  <= '0;
      pending <= 1'b0;
      pollRdy <= 1'b0;
      inPoll  <= 1'b0;
      errFlag <= 1'b0;
      tmoFlag <= 1'b0;
    end else begin
      state   <= stateN;
      gapNext <= gapNextN;
      opReg   <= opRegN;
      clsReg  <= clsRegN;
      pollRdy <= pollRdyN;
      inPoll  <= inPollN;
      errFlag <= errFlagN;
      tmoFlag <= tmoFlagN;
      if (xferStart)     pending <= 1'b1;
      else if (byteDone) pending <= 1'b0;
    end
  end

  assign done    = (state == S_FIN);
  assign error   = done && errFlag;
  assign timeout = done && tmoFlag;

  p_start_in_frame_r9: assert property (@(posedge clk) disable iff (!rstN)
    xferStart |-> csActive) else $error("byte started outside a frame");

  p_start_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    xferStart |=> !xferStart) else $error("back-to-back byte starts");

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done) else $error("done held longer than a cycle");

  p_tmo_err_r8: assert property (@(posedge clk) disable iff (!rstN)
    timeout |-> (error && !csActive)) else $error("timeout without error");

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import fcs_pkg::*;
#(
  parameter bit FAST_READ   = 1'b1,
  parameter int CNT_W       = 16,
  parameter int PROG_LEN    = 256,
  parameter int TIMEOUT_CYC = 250_000_000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [1:0]       reqOp,
  input  logic [1:0]       reqClass,
  input  logic [23:0]      reqAddr,
  input  logic [CNT_W-1:0] reqCount,
  input  logic [7:0]       wrData,
  output logic             wrTake,
  output logic [7:0]       rdData,
  output logic             rdValid,
  output logic             csActive,
  output logic             xferStart,
  output logic [7:0]       xferTx,
  input  logic             xferDone,
  input  logic [7:0]       xferRx,
  output logic             done,
  output logic             error,
  output logic             timeout
);

  strobe_t     st;
  logic [23:0] addr;
  logic        burstLast, burstZero, remainZero, tmoHit;

  fcs_ctrl #(.FAST_READ(FAST_READ), .CNT_W(CNT_W)) u_ctrl (
    .clk, .rstN, .reqValid, .reqOp, .reqClass, .reqCount,
    .addr, .burstLast, .burstZero, .remainZero, .tmoHit,
    .xferDone, .statKey({xferRx[7], xferRx[1], xferRx[0]}), .wrData,
    .st, .xferStart, .xferTx, .wrTake, .csActive,
    .done, .error, .timeout
  );

  fcs_dp #(.CNT_W(CNT_W), .PROG_LEN(PROG_LEN), .TIMEOUT_CYC(TIMEOUT_CYC)) u_dp (
    .clk, .rstN, .st, .reqAddr, .reqCount, .xferRx,
    .addr, .burstLast, .burstZero, .remainZero, .tmoHit,
    .rdData, .rdValid
  );

endmodule

// File: tb/flash_cmd_seq_bench.sv
module flash_cmd_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int PLEN = 8;
  localparam int TMO  = 300;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [1:0] reqOp = '0, reqClass = '0;
  logic [23:0] reqAddr = '0;
  logic [15:0] reqCount = '0;
  logic [7:0] wrData = 8'h5A;
  logic wrTake, rdValid, csActive, xferStart, done, error, timeout;
  logic [7:0] rdData, xferTx;
  logic xferDone = 1'b0;
  logic [7:0] xferRx = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_seq #(.FAST_READ(1'b1), .CNT_W(16), .PROG_LEN(PLEN), .TIMEOUT_CYC(TMO)) u_flash_cmd_seq (
    .clk, .rstN, .reqValid, .reqOp, .reqClass, .reqAddr, .reqCount,
    .wrData, .wrTake, .rdData, .rdValid, .csActive, .xferStart, .xferTx,
    .xferDone, .xferRx, .done, .error, .timeout
  );

  typedef struct packed {
    logic [1:0] op; logic [1:0] cls; logic [23:0] addr; logic [15:0] cnt; logic [7:0] busy;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{2'b00, 2'b00, 24'h123456, 16'd4,  8'd0},
    '{2'b01, 2'b00, 24'h0A0000, 16'd0,  8'd2},
    '{2'b01, 2'b01, 24'h001000, 16'd0,  8'd1},
    '{2'b01, 2'b10, 24'h040000, 16'd0,  8'd3},
    '{2'b10, 2'b00, 24'h000100, 16'd20, 8'd1},
    '{2'b10, 2'b11, 24'h00FFFC, 16'd10, 8'd0},
    '{2'b00, 2'b11, 24'hFFFFFF, 16'd2,  8'd0}
  };

  int total = 0, fails = 0;
  logic [8:0] txLog [0:511];
  logic [8:0] expLog [0:511];
  logic [7:0] rdLog [0:63];
  int txN = 0, expN = 0, rdN = 0, wrIdx = 0, outside = 0;
  int byteIdx = 0, lat = 0;
  logic [7:0] f0 = '0, resp;
  logic wel = 1'b0;
  int busy = 0, busyLoad = 0;
  logic gotErr, gotTmo;

  task automatic check(input string tag, input bit ok, input int act, input int expv);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, expv);
    end
  endtask

  // flash and byte-exchange model
  initial forever begin
    @(negedge clk);
    xferDone = 1'b0;
    if (!csActive) byteIdx = 0;
    if (lat > 0) begin
      lat--;
      if (lat == 0) xferDone = 1'b1;
    end else if (xferStart) begin
      if (!csActive) outside++;
      if (txN < 512) txLog[txN] = {byteIdx == 0, xferTx};
      txN++;
      resp = 8'h00;
      if (byteIdx == 0) begin
        f0 = xferTx;
        if (xferTx == 8'h06) wel = 1'b1;
        if (xferTx inside {8'hD8, 8'h20, 8'h81, 8'h02, 8'h82}) begin
          wel = 1'b0; busy = busyLoad;
        end
      end else if (byteIdx == 1 && f0 inside {8'h05, 8'hD7}) begin
        // busy std: bit7 set; busy alt: bit0 set
        if (f0 == 8'h05) resp = 8'h80 | {6'd0, wel, busy != 0};
        else             resp = (busy != 0) ? 8'h01 : 8'h81;
        if (busy != 0 && busyLoad != 255) busy--;
      end else if (f0 == 8'h0B && byteIdx >= 5) begin
        resp = 8'hC0 + 8'(byteIdx - 5);
      end
      if (wrTake) begin
        wrIdx++;
        wrData = 8'(wrIdx) ^ 8'h5A;
      end
      xferRx = resp;
      byteIdx++;
      lat = 2;
    end
    if (rdValid && rdN < 64) begin
      rdLog[rdN] = rdData;
      rdN++;
    end
  end

  task automatic push(input bit first, input logic [7:0] b);
    expLog[expN] = {first, b};
    expN++;
  endtask

  task automatic buildExp(input vec_t v);
    logic [23:0] a;
    int left, n, d;
    expN = 0; a = v.addr; left = v.cnt; d = 0;
    if (v.op == 2'b00) begin
      push(1, 8'h0B); push(0, a[23:16]); push(0, a[15:8]); push(0, a[7:0]); push(0, 8'h00);
      for (int i = 0; i < left; i++) push(0, 8'h00);
    end else begin
      do begin
        n = (v.op == 2'b10) ? ((left > PLEN) ? PLEN : left) : 0;
        if (!v.cls[1]) begin
          push(1, 8'h06); push(1, 8'h05); push(0, 8'h00);
        end
        push(1, (v.op == 2'b01) ? (v.cls[1] ? 8'h81 : (v.cls[0] ? 8'h20 : 8'hD8))
                                : (v.cls[1] ? 8'h82 : 8'h02));
        push(0, a[23:16]); push(0, a[15:8]); push(0, a[7:0]);
        for (int i = 0; i < n; i++) begin push(0, 8'(d) ^ 8'h5A); d++; end
        for (int i = 0; i <= int'(v.busy); i++) begin
          push(1, v.cls[1] ? 8'hD7 : 8'h05); push(0, 8'h00);
        end
        a = a + 24'(n); left -= n;
      end while (left > 0);
    end
  endtask

  task automatic runReq(input vec_t v);
    int guard;
    busyLoad = v.busy; busy = 0;
    txN = 0; rdN = 0; wrIdx = 0; wrData = 8'h5A; outside = 0;
    @(negedge clk);
    reqValid = 1'b1; reqOp = v.op; reqClass = v.cls; reqAddr = v.addr; reqCount = v.cnt;
    @(negedge clk);
    reqValid = 1'b0;
    guard = 0;
    while (!done && guard < 20000) begin @(negedge clk); guard++; end
    gotErr = error; gotTmo = timeout;
    check("R10 done reached", done == 1'b1, done, 1);
    @(negedge clk);
    check("R10 done one cycle", done == 1'b0, done, 0);
    @(negedge clk);
  endtask

  task automatic cmpStream(input string tag);
    int bad;
    bad = -1;
    for (int i = 0; i < expN && i < txN; i++)
      if (bad < 0 && txLog[i] != expLog[i]) bad = i;
    check({tag, " byte count"}, txN == expN, txN, expN);
    if (bad >= 0) check({tag, " byte value"}, 1'b0, int'(txLog[bad]), int'(expLog[bad]));
    else          check({tag, " byte value"}, 1'b1, 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; total++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    vec_t v;
    string tag;
    repeat (3) @(negedge clk);
    // R10: idle state after reset
    check("R10 reset done", done == 1'b0, done, 0);
    check("R10 reset cs", csActive == 1'b0, csActive, 0);
    check("R10 reset start", xferStart == 1'b0, xferStart, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    foreach (VECS[k]) begin
      v = VECS[k];
      if (v.op == 2'b00)   tag = "R1 read frame";
      else if (v.cls[1])   tag = "R4 R6 alt class";
      else if (v.op == 2'b01) tag = "R3 R5 R6 std erase";
      else                 tag = "R3 R5 R7 std program";
      buildExp(v);
      runReq(v);
      cmpStream(tag);
      check("R10 no error", gotErr == 1'b0, gotErr, 0);
      check("R9 start inside frame", outside == 0, outside, 0);
      if (v.op == 2'b00) begin
        check("R2 read count", rdN == int'(v.cnt), rdN, v.cnt);
        for (int i = 0; i < rdN; i++)
          check("R2 read byte", rdLog[i] == 8'hC0 + 8'(i), rdLog[i], 8'hC0 + 8'(i));
      end
      if (v.op == 2'b10) check("R7 bytes consumed", wrIdx == int'(v.cnt), wrIdx, v.cnt);
    end

    // R11: zero-length program sends nothing
    v = '{2'b10, 2'b00, 24'h000010, 16'd0, 8'd0};
    runReq(v);
    check("R11 program zero frames", txN == 0, txN, 0);
    check("R11 program zero error", gotErr == 1'b0, gotErr, 0);

    // R11: zero-length read sends header only
    v = '{2'b00, 2'b00, 24'h00ABCD, 16'd0, 8'd0};
    buildExp(v);
    runReq(v);
    cmpStream("R11 read zero");
    check("R11 read zero data", rdN == 0, rdN, 0);

    // R10: reserved operation
    v = '{2'b11, 2'b00, 24'h0, 16'd3, 8'd0};
    runReq(v);
    check("R10 reserved error", gotErr == 1'b1, gotErr, 1);
    check("R10 reserved frames", txN == 0, txN, 0);

    // R8: part stays busy forever
    v = '{2'b01, 2'b00, 24'h020000, 16'd0, 8'd255};
    runReq(v);
    check("R8 timeout error", gotErr == 1'b1, gotErr, 1);
    check("R8 timeout flag", gotTmo == 1'b1, gotTmo, 1);
    check("R8 cs released", csActive == 1'b0, csActive, 0);

    // R8: recovery with a normal read
    v = '{2'b00, 2'b00, 24'h000777, 16'd3, 8'd0};
    buildExp(v);
    runReq(v);
    cmpStream("R8 after timeout");
    check("R8 after timeout no error", gotErr == 1'b0 && gotTmo == 1'b0, gotErr, 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule